// File: doc/BRIEF.md
# Oversampled Start-Stop Serial Receiver

This block rebuilds characters from a single asynchronous serial line that rests at logic 1. A free-running tick at sixteen times the bit rate paces it. A falling edge seen on a tick opens a candidate frame. The receiver re-checks the line halfway through the start bit, then takes one sample at the centre of every following bit. It assembles five to eight data bits, least significant first, and can check an optional parity bit. It then tests one or two stop bits.

Each finished character goes into a one-deep holding stage that the host empties with a read strobe. The holding stage reports four separate line-error classes next to the data-ready indication: parity mismatch, bad stop bit (framing), line held low through a whole frame (break), and a character lost because the host had not read its predecessor (overrun). Word length, parity and stop-bit count are captured when a start bit is detected. They apply to that whole frame.

The frame controller has seven states. RX_IDLE waits for a low line on a tick and goes to RX_START. RX_START counts eight ticks. A high sample there is a glitch and returns to RX_IDLE, and a low sample goes to RX_DATA. RX_DATA samples every sixteen ticks. After the last data bit it goes to RX_PAR when parity is enabled and to RX_STOP1 otherwise. RX_PAR goes to RX_STOP1. RX_STOP1 goes to RX_RECOVER on a low sample. On a high sample it goes to RX_STOP2 when two stop bits are selected and to RX_IDLE otherwise. RX_STOP2 goes to RX_IDLE on a high sample and to RX_RECOVER on a low one. RX_RECOVER waits for a tick with the line high and then returns to RX_IDLE. The holding stage has two states. HOLD_EMPTY goes to HOLD_FULL when a character completes. HOLD_FULL goes to HOLD_EMPTY on a read without a new character in the same cycle.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, and while the line stays high, data_o is 0x00 and ready_o, par_err_o, frm_err_o, brk_o and ovr_o are all 0.
- R2: A low level that is high again at the 8th tick after it was first seen is discarded as a glitch. No character is reported, and the receiver goes back to waiting for a start bit.
- R3: Data bits arrive least significant first. width_sel selects 00=5, 01=6, 10=7, 11=8 data bits. The character appears right-justified on data_o with unused upper bits 0, and ready_o becomes 1.
- R4: With par_en_i=1 a parity bit follows the data. par_odd_i=0 requires an even and par_odd_i=1 an odd count of ones over data plus parity bit, and a violation sets par_err_o. With par_en_i=0 no parity bit is taken and par_err_o stays 0.
- R5: stop2_i=1 expects two stop bits, stop2_i=0 one. A 0 sampled in any expected stop bit sets frm_err_o.
- R6: If every sample from the start bit through the first stop bit is 0, the character is reported as 0x00 with brk_o and frm_err_o set. No further character is reported until the line has returned high.
- R7: A character that completes while ready_o is still 1 sets ovr_o and replaces data_o with the new character.
- R8: A one-cycle rd_i pulse clears ready_o and all four error flags on the next clock edge.
- R9: Each bit after the start bit is sampled 16 ticks after the previous sample. The first data sample comes 24 ticks after the start bit is detected, so a frame whose bits each last 16 ticks decodes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line_i | input | 1 | Serial line, idles high |
| tick_i | input | 1 | One-cycle pulse at 16x bit rate |
| width_sel_i | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| stop2_i | input | 1 | 1 = two stop bits |
| rd_i | input | 1 | Host read strobe |
| data_o | output | 8 | Last received character |
| ready_o | output | 1 | Unread character held |
| par_err_o | output | 1 | Parity mismatch |
| frm_err_o | output | 1 | Stop bit sampled low |
| brk_o | output | 1 | Line low for a whole frame |
| ovr_o | output | 1 | Unread character overwritten |

## Verification
The assertions assume that tick_i is a single-cycle pulse, spaced several clocks apart, and that rd_i is a single-cycle strobe. They also assume that the serial line changes slowly compared with the clock, so that the synchronizer delay stays far below one tick period. The bench generates ticks every fourth clock and changes the line only in the cycle after a tick. It holds each bit for exactly sixteen ticks and pulses rd_i for one cycle. It sweeps every combination of word length, parity mode and stop count against computed expected bytes and flags. It changes the configuration only between frames.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP1,
        RX_STOP2,
        RX_RECOVER
    } rx_state_e;

    typedef enum logic {
        HOLD_EMPTY,
        HOLD_FULL
    } hold_state_e;

    typedef struct packed {
        logic [1:0] width;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
    } rx_cfg_t;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import serrx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          line_i,
    input  rx_cfg_t       cfg_i,
    output logic          done_o,
    output logic [DW-1:0] data_o,
    output logic          perr_o,
    output logic          ferr_o,
    output logic          brk_o
);
    localparam int CW   = $clog2(OVS);
    localparam int IW   = $clog2(DW);
    localparam int HALF = OVS / 2;
    localparam int MINB = DW - 3;

    rx_state_e      state, state_n;
    logic [CW-1:0]  cnt;
    logic [IW-1:0]  bit_idx;
    logic [DW-1:0]  shreg;
    logic           pbit;
    logic           all_low;
    rx_cfg_t        cfg_q;

    logic mid_hit, bit_end, last_bit, start_seen, fin;

    assign mid_hit    = tick_i && (cnt == CW'(HALF - 1));
    assign bit_end    = tick_i && (cnt == CW'(OVS - 1));
    assign last_bit   = (bit_idx == (IW'(MINB - 1) + IW'(cfg_q.width)));
    assign start_seen = (state == RX_IDLE) && tick_i && !line_i;
    assign fin        = ((state == RX_STOP1) && bit_end && (!line_i || !cfg_q.stop2))
                     || ((state == RX_STOP2) && bit_end);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            RX_IDLE:    if (start_seen) state_n = RX_START;
            RX_START:   if (mid_hit) state_n = line_i ? RX_IDLE : RX_DATA;
            RX_DATA:    if (bit_end && last_bit)
                            state_n = cfg_q.par_en ? RX_PAR : RX_STOP1;
            RX_PAR:     if (bit_end) state_n = RX_STOP1;
            RX_STOP1:   if (bit_end) begin
                            if (!line_i)          state_n = RX_RECOVER;
                            else if (cfg_q.stop2) state_n = RX_STOP2;
                            else                  state_n = RX_IDLE;
                        end
            RX_STOP2:   if (bit_end) state_n = line_i ? RX_IDLE : RX_RECOVER;
            RX_RECOVER: if (tick_i && line_i) state_n = RX_IDLE;
            default:    state_n = RX_IDLE;
        endcase
    end

    // bit timing and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            pbit    <= 1'b0;
            all_low <= 1'b0;
            cfg_q   <= '0;
        end else begin
            if (state == RX_IDLE || state == RX_RECOVER) begin
                cnt <= '0;
            end else if (tick_i) begin
                if (((state == RX_START) && mid_hit) || bit_end) cnt <= '0;
                else                                            cnt <= cnt + 1'b1;
            end
            if (start_seen) begin
                bit_idx <= '0;
                shreg   <= '0;
                pbit    <= 1'b0;
                all_low <= 1'b1;
                cfg_q   <= cfg_i;
            end
            if ((state == RX_DATA) && bit_end) begin
                shreg[bit_idx] <= line_i;
                bit_idx        <= bit_idx + 1'b1;
                all_low        <= all_low & !line_i;
            end
            if ((state == RX_PAR) && bit_end) begin
                pbit    <= line_i;
                all_low <= all_low & !line_i;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o <= 1'b0;
            data_o <= '0;
            perr_o <= 1'b0;
            ferr_o <= 1'b0;
            brk_o  <= 1'b0;
        end else begin
            done_o <= fin;
            if (fin) begin
                data_o <= shreg;
                perr_o <= cfg_q.par_en && ((^shreg ^ pbit) != cfg_q.par_odd);
                ferr_o <= !line_i;
                brk_o  <= (state == RX_STOP1) && !line_i && all_low;
            end
        end
    end

    assert_glitch_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && mid_hit && line_i) |=> (state == RX_IDLE));

    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_no_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !cfg_q.par_en) |=> !perr_o);

    assert_recover_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_RECOVER && !line_i) |=> (state == RX_RECOVER));

endmodule

// File: rtl/rx_status.sv
module rx_status
    import serrx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done_i,
    input  logic [DW-1:0] data_i,
    input  logic          perr_i,
    input  logic          ferr_i,
    input  logic          brk_i,
    input  logic          rd_i,
    output logic [DW-1:0] data_o,
    output logic          ready_o,
    output logic          perr_o,
    output logic          ferr_o,
    output logic          brk_o,
    output logic          ovr_o
);
    hold_state_e hold, hold_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold <= HOLD_EMPTY;
        else        hold <= hold_n;
    end

    always_comb begin
        hold_n = hold;
        unique case (hold)
            HOLD_EMPTY: if (done_i) hold_n = HOLD_FULL;
            HOLD_FULL:  if (rd_i && !done_i) hold_n = HOLD_EMPTY;
            default:    hold_n = HOLD_EMPTY;
        endcase
    end

    assign ready_o = (hold == HOLD_FULL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
            perr_o <= 1'b0;
            ferr_o <= 1'b0;
            brk_o  <= 1'b0;
            ovr_o  <= 1'b0;
        end else if (done_i) begin
            data_o <= data_i;
            perr_o <= perr_i;
            ferr_o <= ferr_i;
            brk_o  <= brk_i;
            ovr_o  <= ready_o && !rd_i;
        end else if (rd_i) begin
            perr_o <= 1'b0;
            ferr_o <= 1'b0;
            brk_o  <= 1'b0;
            ovr_o  <= 1'b0;
        end
    end

    assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && ready_o && !rd_i) |=> (ovr_o && ready_o));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !done_i) |=> (!ready_o && !ovr_o && !perr_o && !ferr_o && !brk_o));

    assert_hold_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i && !rd_i) |=> ($stable(ready_o) && $stable(data_o)));

    assert_break_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |-> (ferr_o && data_o == '0));

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
    import serrx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_line_i,
    input  logic          tick_i,
    input  logic [1:0]    width_sel_i,
    input  logic          par_en_i,
    input  logic          par_odd_i,
    input  logic          stop2_i,
    input  logic          rd_i,
    output logic [DW-1:0] data_o,
    output logic          ready_o,
    output logic          par_err_o,
    output logic          frm_err_o,
    output logic          brk_o,
    output logic          ovr_o
);
    logic          line_s;
    rx_cfg_t       cfg;
    logic          done;
    logic [DW-1:0] fdata;
    logic          fperr, fferr, fbrk;

    assign cfg = '{width: width_sel_i, par_en: par_en_i,
                   par_odd: par_odd_i, stop2: stop2_i};

    rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_line_i),
        .q_o   (line_s)
    );

    rx_frame_fsm #(.OVS(OVS), .DW(DW)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .line_i (line_s),
        .cfg_i  (cfg),
        .done_o (done),
        .data_o (fdata),
        .perr_o (fperr),
        .ferr_o (fferr),
        .brk_o  (fbrk)
    );

    rx_status #(.DW(DW)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (done),
        .data_i  (fdata),
        .perr_i  (fperr),
        .ferr_i  (fferr),
        .brk_i   (fbrk),
        .rd_i    (rd_i),
        .data_o  (data_o),
        .ready_o (ready_o),
        .perr_o  (par_err_o),
        .ferr_o  (frm_err_o),
        .brk_o   (brk_o),
        .ovr_o   (ovr_o)
    );
endmodule

// File: tb/sim_serial_rx_core.sv
module sim_serial_rx_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] wsel = 2'b11;
    logic       pen = 1'b0, podd = 1'b0, s2 = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] data_o;
    logic       ready_o, perr_o, ferr_o, brk_o, ovr_o;
    logic [1:0] tcnt;
    int         tests = 0, fails = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            tcnt <= '0;
            tick <= 1'b0;
        end else begin
            tcnt <= tcnt + 1'b1;
            tick <= (tcnt == 2'd2);
        end
    end

    serial_rx_core u0 (
        .clk(clk), .rst_n(rst_n), .rx_line_i(line), .tick_i(tick),
        .width_sel_i(wsel), .par_en_i(pen), .par_odd_i(podd), .stop2_i(s2),
        .rd_i(rd), .data_o(data_o), .ready_o(ready_o), .par_err_o(perr_o),
        .frm_err_o(ferr_o), .brk_o(brk_o), .ovr_o(ovr_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            while (tick !== 1'b1) @(posedge clk);
        end
        @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input bit flip_par,
                              input bit bad1, input bit bad2);
        int nb;
        logic [7:0] dm;
        nb = 5 + int'(wsel);
        dm = d & 8'((1 << nb) - 1);
        line = 1'b0; wait_ticks(16);
        for (int i = 0; i < nb; i++) begin
            line = d[i]; wait_ticks(16);
        end
        if (pen) begin
            line = (^dm) ^ podd ^ flip_par; wait_ticks(16);
        end
        line = !bad1; wait_ticks(16);
        if (s2) begin
            line = !bad2; wait_ticks(16);
        end
        line = 1'b1; wait_ticks(16);
    endtask

    function automatic logic [31:0] flags();
        return {27'd0, ready_o, perr_o, ferr_o, brk_o, ovr_o};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wait_ticks(40);
        // R1: reset state with idle line
        check("R1 data", {24'd0, data_o}, 32'h00);
        check("R1 flags", flags(), 32'h0);

        // R2: short low pulse rejected
        line = 1'b0; wait_ticks(5);
        line = 1'b1; wait_ticks(40);
        check("R2 glitch ignored", flags(), 32'h0);
        send_frame(8'hA7, 0, 0, 0);
        check("R2 recovers R9", {24'd0, data_o}, 32'hA7);
        pulse_rd();

        // R3 R4 R5 R9: sweep of all configurations
        for (int c = 0; c < 32; c++) begin
            for (int k = 0; k < 3; k++) begin
                logic [7:0] d, dm;
                @(negedge clk);
                wsel = c[1:0]; pen = c[2]; podd = c[3]; s2 = c[4];
                d  = 8'(c * 53 + k * 91 + 17);
                dm = d & 8'((1 << (5 + c[1:0])) - 1);
                send_frame(d, 0, 0, 0);
                check("R3 data", {24'd0, data_o}, {24'd0, dm});
                check("R4 R5 flags", flags(), 32'h10);
                pulse_rd();
                check("R8 cleared", flags(), 32'h0);
            end
        end

        // R4: corrupted parity, both senses
        wsel = 2'b11; pen = 1'b1; s2 = 1'b0;
        for (int o = 0; o < 2; o++) begin
            podd = o[0];
            send_frame(8'h6B, 1, 0, 0);
            check("R4 parity error", flags(), 32'h18);
            check("R4 data", {24'd0, data_o}, 32'h6B);
            pulse_rd();
        end
        pen = 1'b0;

        // R5: bad first stop bit, then bad second stop bit
        send_frame(8'h5A, 0, 1, 0);
        check("R5 stop1 framing", flags(), 32'h14);
        pulse_rd();
        s2 = 1'b1;
        send_frame(8'h5A, 0, 0, 1);
        check("R5 stop2 framing", flags(), 32'h14);
        check("R5 data", {24'd0, data_o}, 32'h5A);
        pulse_rd();
        s2 = 1'b0;

        // R6: break
        line = 1'b0; wait_ticks(164);
        check("R6 break flags", flags(), 32'h16);
        check("R6 break data", {24'd0, data_o}, 32'h00);
        pulse_rd();
        wait_ticks(100);
        check("R6 no second char", flags(), 32'h0);
        line = 1'b1; wait_ticks(40);
        check("R6 after release", flags(), 32'h0);

        // R7: overrun
        send_frame(8'h3C, 0, 0, 0);
        send_frame(8'hC5, 0, 0, 0);
        check("R7 overrun flags", flags(), 32'h11);
        check("R7 new data", {24'd0, data_o}, 32'hC5);
        pulse_rd();
        check("R8 read clears", flags(), 32'h0);
        check("R8 data kept", {24'd0, data_o}, 32'hC5);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule